// File: doc/BRIEF.md
# Banked Code and Data Address Mapper

This block sits beside an 8032-class microcontroller core. It turns the core's 16-bit code-fetch address and its 16-bit external-data address into a physical target and a physical address within that target. The lower half of code space always reaches the bottom 32 KB of external flash. The upper half is a window onto one of four 32 KB flash banks. A software-selected overlay can instead place the first 2 KB of on-chip scratch RAM at the top 2 KB of code space. Firmware copies its flash-update routine there and runs it from RAM while the flash is being rewritten.

On the data side, the 4 KB scratch RAM occupies the bottom of data space at all times, whether or not the overlay is on. A peripheral register region sits above it, and the rest of data space is unmapped and reads as all ones. The block holds two configuration registers inside the peripheral region, a bank-select register and an overlay register. The core writes and reads them with ordinary data accesses. The translation itself is combinational, so each access is resolved in the cycle in which its address is presented.

Top module: `bank_addr_mapper`

## Requirements
- R1: A code address below 0x8000 gives target flash (code), and the physical address equals the code address.
- R2: A code address from 0x8000 to 0xFFFF that the overlay does not claim gives target flash. Its physical address is (bank + 1) * 0x8000 + (address mod 0x8000), so bank 3 with address 0xFFFF gives 0x27FFF.
- R3: A data write to 0x1100 loads bits [1:0] of the write data into the bank register. The new bank governs code translation from the clock after the write, and a read of 0x1100 returns the bank in bits [1:0] with zeros above.
- R4: While bit 7 of the overlay register is 1, code addresses 0xF800 to 0xFFFF give target scratch at physical address (address - 0xF800); for example, 0xFE00 maps to 0x600. Code addresses below 0xF800 are not affected.
- R5: A data write to 0x1101 loads all 8 bits of the overlay register, and a read of 0x1101 returns them. Only bit 7 has any effect on translation.
- R6: A data address from 0x0000 to 0x0FFF gives target scratch, physical address equal to the address, and read data from the scratch read input, whatever the overlay setting.
- R7: A data address from 0x1000 to 0x3000 inclusive gives target peripheral, physical address (address - 0x1000), and read data from the peripheral read input, except at the two register addresses.
- R8: A data address above 0x3000 gives target unmapped, physical address 0 and read data 0xFF. A write there changes neither register.
- R9: While reset is asserted, and after it is released, the bank is 0 and the overlay is off.
- R10: With the write strobe low, no data address or write data changes either register.
- Target encoding for both target outputs: 0 = flash, 1 = scratch, 2 = peripheral, 3 = unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| code_addr | input | 16 | Code-fetch address from the core |
| code_tgt | output | 2 | Code target (0 flash, 1 scratch) |
| code_phys | output | 18 | Physical flash or scratch address for the fetch |
| data_addr | input | 16 | External-data address from the core |
| data_wr | input | 1 | Data write strobe |
| data_wdata | input | 8 | Data write value |
| scratch_rdata | input | 8 | Read data returned by the scratch RAM |
| periph_rdata | input | 8 | Read data returned by the peripheral registers |
| data_tgt | output | 2 | Data target (0 flash, 1 scratch, 2 peripheral, 3 unmapped) |
| data_phys | output | 14 | Physical address within the scratch or peripheral target |
| data_rdata | output | 8 | Read data seen by the core |

## Verification
The targets, physical addresses and read data are combinational functions of the current addresses and the register state. They are therefore due in the same cycle that an address is presented. The bench changes addresses on the falling edge and compares a few nanoseconds later, before the next rising edge. A register write only takes effect on the rising edge that follows its strobe, and the internal reset synchroniser holds the registers for two edges after reset release. The reference model applies each write on that same rising edge and discards writes inside the synchroniser window, so every check after a write already expects the new bank or overlay value.

// File: rtl/bam_pkg.sv
package bam_pkg;
  typedef enum logic [1:0] {
    TGT_FLASH   = 2'd0,
    TGT_SCRATCH = 2'd1,
    TGT_PERIPH  = 2'd2,
    TGT_NONE    = 2'd3
  } bam_tgt_e;
endpackage

// File: rtl/bam_cfg_regs.sv
module bam_cfg_regs #(
  parameter int BANK_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              sel_bank,
  input  logic              sel_ovl,
  input  logic [DATA_W-1:0] wdata,
  output logic [BANK_W-1:0] bank_q,
  output logic [DATA_W-1:0] ovl_q
);
  logic              bank_ce;
  logic              ovl_ce;
  logic [BANK_W-1:0] bank_d;
  logic [DATA_W-1:0] ovl_d;

  always_comb begin
    bank_ce = wr_en & sel_bank;
    ovl_ce  = wr_en & sel_ovl;
    bank_d  = wdata[BANK_W-1:0];
    ovl_d   = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= '0;
    end else if (bank_ce) begin
      bank_q <= bank_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovl_q <= '0;
    end else if (ovl_ce) begin
      ovl_q <= ovl_d;
    end
  end
endmodule

// File: rtl/bam_code_xlate.sv
module bam_code_xlate
  import bam_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 2,
  parameter int OVL_AW  = 11,
  parameter int PHYS_W  = 18
) (
  input  logic [ADDR_W-1:0] code_addr,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ovl_en,
  output bam_tgt_e          tgt,
  output logic [PHYS_W-1:0] phys
);
  localparam int WIN_AW = ADDR_W - 1;
  localparam int TOP_W  = ADDR_W - OVL_AW;

  logic in_window;
  logic ovl_hit;
  logic [PHYS_W-1:0] bank_base;

  always_comb begin
    in_window = code_addr[ADDR_W-1];
    ovl_hit   = ovl_en && (code_addr[ADDR_W-1:OVL_AW] == {TOP_W{1'b1}});
    bank_base = (PHYS_W'(bank_sel) + PHYS_W'(1)) << WIN_AW;
    tgt       = TGT_FLASH;
    phys      = PHYS_W'(code_addr);
    if (ovl_hit) begin
      tgt  = TGT_SCRATCH;
      phys = PHYS_W'(code_addr[OVL_AW-1:0]);
    end else if (in_window) begin
      phys = bank_base | PHYS_W'(code_addr[WIN_AW-1:0]);
    end
  end
endmodule

// File: rtl/bam_data_xlate.sv
module bam_data_xlate
  import bam_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int BANK_W        = 2,
  parameter int SCR_AW        = 12,
  parameter int PER_BASE      = 'h1000,
  parameter int PER_LAST      = 'h3000,
  parameter int BANK_REG_ADDR = 'h1100,
  parameter int OVL_REG_ADDR  = 'h1101,
  parameter int DPHYS_W       = 14
) (
  input  logic [ADDR_W-1:0]  data_addr,
  input  logic [BANK_W-1:0]  bank_q,
  input  logic [DATA_W-1:0]  ovl_q,
  input  logic [DATA_W-1:0]  scratch_rdata,
  input  logic [DATA_W-1:0]  periph_rdata,
  output bam_tgt_e           tgt,
  output logic [DPHYS_W-1:0] phys,
  output logic [DATA_W-1:0]  rdata,
  output logic               sel_bank,
  output logic               sel_ovl
);
  localparam logic [ADDR_W-1:0] SCR_LIM_A = ADDR_W'(2 ** SCR_AW);
  localparam logic [ADDR_W-1:0] PER_LO_A  = ADDR_W'(PER_BASE);
  localparam logic [ADDR_W-1:0] PER_HI_A  = ADDR_W'(PER_LAST);
  localparam logic [ADDR_W-1:0] BANK_A    = ADDR_W'(BANK_REG_ADDR);
  localparam logic [ADDR_W-1:0] OVL_A     = ADDR_W'(OVL_REG_ADDR);

  logic in_scr;
  logic in_per;

  always_comb begin
    in_scr   = data_addr < SCR_LIM_A;
    in_per   = (data_addr >= PER_LO_A) && (data_addr <= PER_HI_A);
    sel_bank = data_addr == BANK_A;
    sel_ovl  = data_addr == OVL_A;
    tgt      = TGT_NONE;
    phys     = '0;
    rdata    = '1;
    if (in_scr) begin
      tgt   = TGT_SCRATCH;
      phys  = DPHYS_W'(data_addr[SCR_AW-1:0]);
      rdata = scratch_rdata;
    end else if (in_per) begin
      tgt  = TGT_PERIPH;
      phys = DPHYS_W'(data_addr - PER_LO_A);
      if (sel_bank) begin
        rdata = DATA_W'(bank_q);
      end else if (sel_ovl) begin
        rdata = ovl_q;
      end else begin
        rdata = periph_rdata;
      end
    end
  end
endmodule

// File: rtl/bank_addr_mapper.sv
module bank_addr_mapper
  import bam_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int BANKS         = 4,
  parameter int SCR_AW        = 12,
  parameter int OVL_AW        = 11,
  parameter int OVL_BIT       = 7,
  parameter int PER_BASE      = 'h1000,
  parameter int PER_LAST      = 'h3000,
  parameter int BANK_REG_ADDR = 'h1100,
  parameter int OVL_REG_ADDR  = 'h1101,
  localparam int BANK_W       = $clog2(BANKS),
  localparam int PHYS_W       = $clog2((BANKS + 1) * (2 ** (ADDR_W - 1))),
  localparam int PER_W        = $clog2(PER_LAST - PER_BASE + 1),
  localparam int DPHYS_W      = (SCR_AW > PER_W) ? SCR_AW : PER_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  code_addr,
  output logic [1:0]         code_tgt,
  output logic [PHYS_W-1:0]  code_phys,
  input  logic [ADDR_W-1:0]  data_addr,
  input  logic               data_wr,
  input  logic [DATA_W-1:0]  data_wdata,
  input  logic [DATA_W-1:0]  scratch_rdata,
  input  logic [DATA_W-1:0]  periph_rdata,
  output logic [1:0]         data_tgt,
  output logic [DPHYS_W-1:0] data_phys,
  output logic [DATA_W-1:0]  data_rdata
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [BANK_W-1:0] bank_q;
  logic [DATA_W-1:0] ovl_q;
  logic              ovl_en;
  logic              sel_bank;
  logic              sel_ovl;
  bam_tgt_e          code_tgt_e;
  bam_tgt_e          data_tgt_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end

  always_comb begin
    rst_int_n = rst_sync[1];
    ovl_en    = ovl_q[OVL_BIT];
    code_tgt  = code_tgt_e;
    data_tgt  = data_tgt_e;
  end

  bam_cfg_regs #(
    .BANK_W (BANK_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (data_wr),
    .sel_bank (sel_bank),
    .sel_ovl  (sel_ovl),
    .wdata    (data_wdata),
    .bank_q   (bank_q),
    .ovl_q    (ovl_q)
  );

  bam_code_xlate #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .OVL_AW (OVL_AW),
    .PHYS_W (PHYS_W)
  ) u_code (
    .code_addr (code_addr),
    .bank_sel  (bank_q),
    .ovl_en    (ovl_en),
    .tgt       (code_tgt_e),
    .phys      (code_phys)
  );

  bam_data_xlate #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .BANK_W        (BANK_W),
    .SCR_AW        (SCR_AW),
    .PER_BASE      (PER_BASE),
    .PER_LAST      (PER_LAST),
    .BANK_REG_ADDR (BANK_REG_ADDR),
    .OVL_REG_ADDR  (OVL_REG_ADDR),
    .DPHYS_W       (DPHYS_W)
  ) u_data (
    .data_addr     (data_addr),
    .bank_q        (bank_q),
    .ovl_q         (ovl_q),
    .scratch_rdata (scratch_rdata),
    .periph_rdata  (periph_rdata),
    .tgt           (data_tgt_e),
    .phys          (data_phys),
    .rdata         (data_rdata),
    .sel_bank      (sel_bank),
    .sel_ovl       (sel_ovl)
  );
endmodule

// File: rtl/bank_addr_mapper_chk.sv
module bank_addr_mapper_chk #(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int BANK_W        = 2,
  parameter int PHYS_W        = 18,
  parameter int OVL_AW        = 11,
  parameter int SCR_AW        = 12,
  parameter int PER_LAST      = 'h3000,
  parameter int BANK_REG_ADDR = 'h1100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] code_addr,
  input logic [1:0]        code_tgt,
  input logic [PHYS_W-1:0] code_phys,
  input logic [ADDR_W-1:0] data_addr,
  input logic              data_wr,
  input logic [BANK_W-1:0] bank_wdata,
  input logic [1:0]        data_tgt,
  input logic [DATA_W-1:0] data_rdata,
  input logic [BANK_W-1:0] bank_q,
  input logic              ovl_en
);
  localparam int WIN_AW = ADDR_W - 1;
  localparam int HI_W   = PHYS_W - WIN_AW;
  localparam int TOP_W  = ADDR_W - OVL_AW;
  localparam logic [ADDR_W-1:0] BANK_A   = ADDR_W'(BANK_REG_ADDR);
  localparam logic [ADDR_W-1:0] SCR_LIM  = ADDR_W'(2 ** SCR_AW);
  localparam logic [ADDR_W-1:0] PER_HI_A = ADDR_W'(PER_LAST);

  a_r1_common_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !code_addr[ADDR_W-1] |-> (code_tgt == 2'd0) && (code_phys == PHYS_W'(code_addr)));

  a_r2_bank_window: assert property (@(posedge clk) disable iff (!rst_n)
    (code_addr[ADDR_W-1] && !ovl_en) |->
      (code_tgt == 2'd0) && (code_phys[WIN_AW-1:0] == code_addr[WIN_AW-1:0]) &&
      (code_phys[PHYS_W-1:WIN_AW] == HI_W'(bank_q) + HI_W'(1)));

  a_r4_overlay_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl_en && (code_addr[ADDR_W-1:OVL_AW] == {TOP_W{1'b1}})) |->
      (code_tgt == 2'd1) && (code_phys == PHYS_W'(code_addr[OVL_AW-1:0])));

  a_r3_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && (data_addr == BANK_A)) |=> (bank_q == $past(bank_wdata)));

  a_r10_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_wr && (data_addr == BANK_A)) |=> $stable(bank_q));

  a_r6_data_scratch: assert property (@(posedge clk) disable iff (!rst_n)
    (data_addr < SCR_LIM) |-> (data_tgt == 2'd1));

  a_r8_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (data_addr > PER_HI_A) |-> (data_tgt == 2'd3) && (data_rdata == {DATA_W{1'b1}}));
endmodule

bind bank_addr_mapper bank_addr_mapper_chk #(
  .ADDR_W        (ADDR_W),
  .DATA_W        (DATA_W),
  .BANK_W        (BANK_W),
  .PHYS_W        (PHYS_W),
  .OVL_AW        (OVL_AW),
  .SCR_AW        (SCR_AW),
  .PER_LAST      (PER_LAST),
  .BANK_REG_ADDR (BANK_REG_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .code_addr  (code_addr),
  .code_tgt   (code_tgt),
  .code_phys  (code_phys),
  .data_addr  (data_addr),
  .data_wr    (data_wr),
  .bank_wdata (data_wdata[BANK_W-1:0]),
  .data_tgt   (data_tgt),
  .data_rdata (data_rdata),
  .bank_q     (bank_q),
  .ovl_en     (ovl_en)
);

// File: tb/bank_addr_mapper_test.sv
module bank_addr_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] code_addr;
  logic [1:0]  code_tgt;
  logic [17:0] code_phys;
  logic [15:0] data_addr;
  logic        data_wr;
  logic [7:0]  data_wdata;
  logic [7:0]  scratch_rdata;
  logic [7:0]  periph_rdata;
  logic [1:0]  data_tgt;
  logic [13:0] data_phys;
  logic [7:0]  data_rdata;

  int checks = 0;
  int errors = 0;
  int ref_bank;
  int ref_ovl;
  int sync_cnt;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bank_addr_mapper uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .code_addr     (code_addr),
    .code_tgt      (code_tgt),
    .code_phys     (code_phys),
    .data_addr     (data_addr),
    .data_wr       (data_wr),
    .data_wdata    (data_wdata),
    .scratch_rdata (scratch_rdata),
    .periph_rdata  (periph_rdata),
    .data_tgt      (data_tgt),
    .data_phys     (data_phys),
    .data_rdata    (data_rdata)
  );

  // Reference model: register state, writes ignored for two edges after reset release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_bank <= 0;
      ref_ovl  <= 0;
      sync_cnt <= 0;
    end else if (sync_cnt < 2) begin
      sync_cnt <= sync_cnt + 1;
    end else if (data_wr) begin
      if (data_addr == 16'h1100) ref_bank <= int'(data_wdata) % 4;
      if (data_addr == 16'h1101) ref_ovl  <= int'(data_wdata);
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int a;
    int et;
    int ep;
    int er;
    string tag;
    a = int'(code_addr);
    if (a < 'h8000) begin
      tag = "R1"; et = 0; ep = a;
    end else if (((ref_ovl / 128) % 2 == 1) && a >= 'hF800) begin
      tag = "R4"; et = 1; ep = a - 'hF800;
    end else begin
      tag = "R2"; et = 0; ep = (ref_bank + 1) * 'h8000 + (a - 'h8000);
    end
    check(tag, "code_tgt", int'(code_tgt), et);
    check(tag, "code_phys", int'(code_phys), ep);
    a = int'(data_addr);
    if (a < 'h1000) begin
      tag = "R6"; et = 1; ep = a; er = int'(scratch_rdata);
    end else if (a <= 'h3000) begin
      et = 2; ep = a - 'h1000;
      if (a == 'h1100) begin
        tag = "R3"; er = ref_bank;
      end else if (a == 'h1101) begin
        tag = "R5"; er = ref_ovl;
      end else begin
        tag = "R7"; er = int'(periph_rdata);
      end
    end else begin
      tag = "R8"; et = 3; ep = 0; er = 'hFF;
    end
    check(tag, "data_tgt", int'(data_tgt), et);
    check(tag, "data_phys", int'(data_phys), ep);
    check(tag, "data_rdata", int'(data_rdata), er);
  endtask

  // Compare against the model on every cycle, after inputs settle at the falling edge
  always @(negedge clk) begin
    #2;
    if (cmp_en && !done) compare_all();
  end

  task automatic drive(input logic [15:0] ca, input logic [15:0] da, input logic wr, input logic [7:0] wd);
    @(negedge clk);
    code_addr  = ca;
    data_addr  = da;
    data_wr    = wr;
    data_wdata = wd;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R1..R10 run): actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    code_addr = 16'h9234; data_addr = 16'h1100; data_wr = 1'b0; data_wdata = 8'h00;
    scratch_rdata = 8'hA5; periph_rdata = 8'h3C;
    repeat (3) @(negedge clk);
    #3;
    // R9: reset state, bank 0 and overlay off
    check("R9", "code_phys reset bank", int'(code_phys), 'h9234);
    check("R9", "bank readback", int'(data_rdata), 0);
    code_addr = 16'hFE00; data_addr = 16'h1101;
    #1;
    check("R9", "overlay off code_tgt", int'(code_tgt), 0);
    check("R9", "overlay readback", int'(data_rdata), 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;
    repeat (4) drive(16'h0000, 16'h0000, 1'b0, 8'h00);

    drive(16'h7FFF, 16'h0FFF, 1'b0, 8'h00);
    drive(16'h8000, 16'h1000, 1'b0, 8'h00);
    drive(16'hFFFF, 16'h3000, 1'b0, 8'h00);
    drive(16'hF800, 16'h3001, 1'b0, 8'h00);

    // R3: bank write takes effect from the next clock
    drive(16'h8123, 16'h1100, 1'b1, 8'hFE);
    drive(16'h8123, 16'h1100, 1'b0, 8'h00);
    #3 check("R3", "bank 2 window", int'(code_phys), 'h18123);

    // R10: strobe low, no change
    drive(16'h8123, 16'h1100, 1'b0, 8'h01);
    drive(16'h8123, 16'h1101, 1'b0, 8'hFF);
    #3 check("R10", "bank held", int'(code_phys), 'h18123);

    drive(16'hFFFF, 16'h1100, 1'b1, 8'h03);
    drive(16'hFFFF, 16'h1100, 1'b0, 8'h00);
    #3 check("R2", "bank 3 top", int'(code_phys), 'h27FFF);

    // R4: overlay on
    drive(16'hFE00, 16'h1101, 1'b1, 8'h80);
    drive(16'hFE00, 16'h0600, 1'b0, 8'h00);
    #3 check("R4", "overlay tgt", int'(code_tgt), 1);
    check("R4", "overlay 0xFE00", int'(code_phys), 'h600);
    check("R6", "scratch still in data", int'(data_tgt), 1);
    drive(16'hF7FF, 16'h1101, 1'b0, 8'h00);
    #3 check("R4", "below overlay", int'(code_phys), 'h277FF);
    check("R5", "overlay readback", int'(data_rdata), 'h80);

    // R5: bits other than 7 have no effect
    drive(16'hFE00, 16'h1101, 1'b1, 8'h7F);
    drive(16'hFE00, 16'h1101, 1'b0, 8'h00);
    #3 check("R5", "overlay low bits only", int'(code_tgt), 0);
    check("R5", "overlay byte readback", int'(data_rdata), 'h7F);

    // R8: write to unmapped space changes nothing
    drive(16'hC000, 16'h3001, 1'b1, 8'h00);
    drive(16'hC000, 16'hFFFF, 1'b1, 8'hFF);
    drive(16'hC000, 16'h1100, 1'b0, 8'h00);
    #3 check("R8", "bank after unmapped write", int'(data_rdata), 3);
    check("R8", "window after unmapped write", int'(code_phys), 'h24000);

    scratch_rdata = 8'h5A; periph_rdata = 8'hC3;
    drive(16'h0001, 16'h2FFF, 1'b0, 8'h00);
    drive(16'h0001, 16'h0001, 1'b0, 8'h00);

    for (int i = 0; i < 400; i++) begin
      int sel;
      logic [15:0] da;
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: da = 16'h1100;
        1: da = 16'h1101;
        2: da = 16'($urandom_range(0, 'h0FFF));
        3: da = 16'($urandom_range('h1000, 'h3000));
        default: da = 16'($urandom_range(0, 'hFFFF));
      endcase
      scratch_rdata = 8'($urandom);
      periph_rdata  = 8'($urandom);
      drive(16'($urandom_range(0, 'hFFFF)) | ((i % 3 == 0) ? 16'hF800 : 16'h0000),
            da, 1'($urandom_range(0, 1)), 8'($urandom));
    end
    drive(16'h0000, 16'h0000, 1'b0, 8'h00);
    @(negedge clk);
    #5;
    finish_run();
  end
endmodule